// File: doc/BRIEF.md
# Tagged Fully Associative Translation Buffer

This block caches virtual-to-physical page translations and searches every resident entry at once. It keeps two separate entry pools. One holds 4 KB pages. The other holds large pages of either 2 MB or 4 MB. Each entry carries an address-space identifier. Translations from several contexts can therefore stay resident together, and a context switch needs no flush. An entry with its global bit set matches under any identifier and survives an identifier-scoped flush. Kernel mappings that every context shares are therefore kept.

The block has three interfaces. A lookup presents a virtual address and the current identifier. One cycle later the block returns a hit flag, the physical address and the page-size code. A fill installs one translation into the pool its size selects. A flush command clears everything, or only the non-global entries of one identifier.

Page-size codes used on the fill and lookup ports: 0 = 4 KB, 1 = 2 MB, 2 = 4 MB, 3 = not a valid size.

Top module: `tagged_tlb`

## Requirements
- R1: While reset is held, and after it is released, every lookup misses. In any cycle after a cycle with no lookup request, `lk_hit` is 0, `lk_pa` is 0 and `lk_size` is 0. A miss also returns `lk_pa` = 0 and `lk_size` = 0.
- R2: The lookup result appears on the outputs in the cycle after the request. A 4 KB entry hits when it is valid, its page number equals `lk_va[47:12]`, and either its identifier equals `lk_asid` or it is global. On such a hit, `lk_pa` = {stored frame, `lk_va[11:0]`} and `lk_size` = 0.
- R3: A fill with size code 0 goes to the small pool. Codes 1 and 2 go to the large pool. Filling one pool never evicts an entry of the other pool. A fill with code 3 is dropped, and a later lookup of that page misses.
- R4: A non-global entry hits only under its own identifier. A global entry hits under any identifier.
- R5: A 2 MB entry matches on `lk_va[47:21]` and returns {frame[27:9], `lk_va[20:0]`} with size code 1. A 4 MB entry matches on `lk_va[47:22]` and returns {frame[27:10], `lk_va[21:0]`} with size code 2. An address one page past the entry misses.
- R6: A flush by identifier clears only the non-global entries whose identifier matches. Entries of other identifiers and global entries keep hitting.
- R7: A flush-all clears every entry, global entries included.
- R8: A lookup in the same cycle as a fill of the same page sees the contents from before the fill, so it misses. A lookup one cycle later hits.
- R9: A fill of a page that is already resident, with the same size, global bit and identifier, overwrites that entry instead of allocating a second one. The next lookup returns the new frame.
- R10: A fill writes the lowest-numbered invalid entry of its pool. When the pool is full, it replaces the entry under that pool's round-robin pointer, which then advances and wraps. The pointer is cleared by reset, so after reset a full pool evicts in fill order.
- R11: A fill in the same cycle as a flush is applied after the flush, so the new entry hits afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_en | input | 1 | Lookup request |
| lk_va | input | VA_W (48) | Virtual address to translate |
| lk_asid | input | ASID_W (8) | Current address-space identifier |
| lk_hit | output | 1 | Registered hit flag |
| lk_pa | output | PA_W (40) | Registered physical address, 0 on miss |
| lk_size | output | 2 | Registered page-size code of the hit, 0 on miss |
| fl_en | input | 1 | Fill request |
| fl_vpn | input | VA_W-12 (36) | Virtual page number at 4 KB granularity |
| fl_pfn | input | PA_W-12 (28) | Physical frame number at 4 KB granularity |
| fl_asid | input | ASID_W (8) | Identifier of the new entry |
| fl_global | input | 1 | Entry matches under every identifier |
| fl_size | input | 2 | Page-size code of the new entry |
| inv_all | input | 1 | Clear every entry |
| inv_asid_en | input | 1 | Clear the non-global entries of one identifier |
| inv_asid | input | ASID_W (8) | Identifier to clear |

## Verification
Two functions can fall in the same cycle: a fill and a lookup of the same page, and a fill and a flush. The bench drives the fill and the lookup of the same page in one cycle. It expects a miss in that cycle and a hit with the new frame one cycle later. It also raises flush-all together with a fill and expects the freshly filled page to hit afterwards. Replacement is swept across three times the small pool depth. Each step is judged by the page filled four fills earlier missing while the three newer pages and a resident large page still hit.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef enum logic [1:0] {
      PG_4K  = 2'd0,
      PG_2M  = 2'd1,
      PG_4M  = 2'd2,
      PG_BAD = 2'd3
   } pg_size_e;

   localparam int unsigned BASE_SHIFT = 12;

   // page-number bits below the match boundary, beyond the 4 KB offset
   function automatic int unsigned extra_bits(pg_size_e s);
      case (s)
         PG_2M:   return 9;
         PG_4M:   return 10;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/tlb_pool.sv
module tlb_pool
   import tlb_pkg::*;
#(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned VPN_W   = 36,
   parameter int unsigned PFN_W   = 28,
   parameter int unsigned ASID_W  = 8,
   parameter bit          LARGE   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              hit,
   output logic [PFN_W-1:0]  hit_pfn,
   output pg_size_e          hit_size,
   input  logic              wr_en,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [PFN_W-1:0]  wr_pfn,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_global,
   input  pg_size_e          wr_size,
   input  logic              clr_all,
   input  logic              clr_asid_en,
   input  logic [ASID_W-1:0] clr_asid
);

   localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   function automatic logic [VPN_W-1:0] keep(pg_size_e s);
      return ~((VPN_W'(1) << extra_bits(s)) - VPN_W'(1));
   endfunction

   logic [ENTRIES-1:0] vld;
   logic [ENTRIES-1:0] glb;
   logic [VPN_W-1:0]   e_vpn  [ENTRIES];
   logic [PFN_W-1:0]   e_pfn  [ENTRIES];
   logic [ASID_W-1:0]  e_asid [ENTRIES];
   pg_size_e           e_size [ENTRIES];

   logic [ENTRIES-1:0] lk_match;
   logic [ENTRIES-1:0] dup_match;
   logic [IDX_W-1:0]   rr_ptr;
   logic [IDX_W-1:0]   wr_idx;
   logic               use_rr;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign lk_match[i] = vld[i]
                        && (((lk_vpn ^ e_vpn[i]) & keep(e_size[i])) == '0)
                        && (glb[i] || (e_asid[i] == lk_asid));
      assign dup_match[i] = vld[i]
                         && (e_size[i] == wr_size)
                         && (((wr_vpn ^ e_vpn[i]) & keep(wr_size)) == '0)
                         && (glb[i] == wr_global)
                         && (wr_global || (e_asid[i] == wr_asid));
   end

   // lowest matching index wins
   always_comb begin
      hit      = 1'b0;
      hit_pfn  = '0;
      hit_size = PG_4K;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (lk_match[i]) begin
            hit      = 1'b1;
            hit_pfn  = e_pfn[i];
            hit_size = e_size[i];
         end
      end
   end

   // victim: existing copy, else lowest free slot, else round-robin
   always_comb begin
      wr_idx = rr_ptr;
      use_rr = 1'b1;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!vld[i]) begin
            wr_idx = IDX_W'(i);
            use_rr = 1'b0;
         end
      end
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (dup_match[i]) begin
            wr_idx = IDX_W'(i);
            use_rr = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld    <= '0;
         rr_ptr <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (clr_all || (clr_asid_en && !glb[i] && (e_asid[i] == clr_asid)))
               vld[i] <= 1'b0;
         end
         if (wr_en)
            vld[wr_idx] <= 1'b1;
         if (wr_en && use_rr)
            rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         e_vpn[wr_idx]  <= wr_vpn & keep(wr_size);
         e_pfn[wr_idx]  <= wr_pfn;
         e_asid[wr_idx] <= wr_asid;
         glb[wr_idx]    <= wr_global;
      end
   end

   if (LARGE) begin : g_size_store
      always_ff @(posedge clk) begin
         if (wr_en)
            e_size[wr_idx] <= wr_size;
      end
   end else begin : g_size_fixed
      for (genvar i = 0; i < ENTRIES; i++) begin : g_fix
         assign e_size[i] = PG_4K;
      end
   end

endmodule

// File: rtl/tagged_tlb.sv
module tagged_tlb
   import tlb_pkg::*;
#(
   parameter int unsigned VA_W    = 48,
   parameter int unsigned PA_W    = 40,
   parameter int unsigned SMALL_N = 32,
   parameter int unsigned LARGE_N = 8,
   parameter int unsigned ASID_W  = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       lk_en,
   input  logic [VA_W-1:0]            lk_va,
   input  logic [ASID_W-1:0]          lk_asid,
   output logic                       lk_hit,
   output logic [PA_W-1:0]            lk_pa,
   output logic [1:0]                 lk_size,
   input  logic                       fl_en,
   input  logic [VA_W-BASE_SHIFT-1:0] fl_vpn,
   input  logic [PA_W-BASE_SHIFT-1:0] fl_pfn,
   input  logic [ASID_W-1:0]          fl_asid,
   input  logic                       fl_global,
   input  logic [1:0]                 fl_size,
   input  logic                       inv_all,
   input  logic                       inv_asid_en,
   input  logic [ASID_W-1:0]          inv_asid
);

   localparam int unsigned VPN_W = VA_W - BASE_SHIFT;
   localparam int unsigned PFN_W = PA_W - BASE_SHIFT;

   initial begin
      assert (PA_W > BASE_SHIFT + 10) else $error("PA_W too narrow for 4 MB pages");
      assert (VA_W >= PA_W)           else $error("VA_W must cover PA_W");
      assert (SMALL_N >= 2)           else $error("small pool needs two entries");
      assert (LARGE_N >= 2)           else $error("large pool needs two entries");
      assert (ASID_W >= 1)            else $error("ASID_W must be positive");
   end

   pg_size_e          fsz;
   logic              s_wr, l_wr;
   logic [VPN_W-1:0]  lk_vpn;
   logic              s_hit, l_hit;
   logic [PFN_W-1:0]  s_pfn, l_pfn, pfn_n;
   pg_size_e          s_size, l_size, sz_n;
   logic [PA_W-1:0]   off_mask, pa_n;

   assign fsz    = pg_size_e'(fl_size);
   assign s_wr   = fl_en && (fsz == PG_4K);
   assign l_wr   = fl_en && ((fsz == PG_2M) || (fsz == PG_4M));
   assign lk_vpn = lk_va[VA_W-1:BASE_SHIFT];

   tlb_pool #(
      .ENTRIES(SMALL_N), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .LARGE(1'b0)
   ) u_small (
      .clk(clk), .rst_n(rst_n),
      .lk_vpn(lk_vpn), .lk_asid(lk_asid),
      .hit(s_hit), .hit_pfn(s_pfn), .hit_size(s_size),
      .wr_en(s_wr), .wr_vpn(fl_vpn), .wr_pfn(fl_pfn), .wr_asid(fl_asid),
      .wr_global(fl_global), .wr_size(fsz),
      .clr_all(inv_all), .clr_asid_en(inv_asid_en), .clr_asid(inv_asid)
   );

   tlb_pool #(
      .ENTRIES(LARGE_N), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .LARGE(1'b1)
   ) u_large (
      .clk(clk), .rst_n(rst_n),
      .lk_vpn(lk_vpn), .lk_asid(lk_asid),
      .hit(l_hit), .hit_pfn(l_pfn), .hit_size(l_size),
      .wr_en(l_wr), .wr_vpn(fl_vpn), .wr_pfn(fl_pfn), .wr_asid(fl_asid),
      .wr_global(fl_global), .wr_size(fsz),
      .clr_all(inv_all), .clr_asid_en(inv_asid_en), .clr_asid(inv_asid)
   );

   // small pool takes priority if both pools hold an overlapping page
   assign pfn_n    = s_hit ? s_pfn  : l_pfn;
   assign sz_n     = s_hit ? s_size : l_size;
   assign off_mask = (PA_W'(1) << (BASE_SHIFT + extra_bits(sz_n))) - PA_W'(1);
   assign pa_n     = ({pfn_n, {BASE_SHIFT{1'b0}}} & ~off_mask)
                   | (lk_va[PA_W-1:0] & off_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_hit  <= 1'b0;
         lk_pa   <= '0;
         lk_size <= 2'd0;
      end else if (lk_en && (s_hit || l_hit)) begin
         lk_hit  <= 1'b1;
         lk_pa   <= pa_n;
         lk_size <= sz_n;
      end else begin
         lk_hit  <= 1'b0;
         lk_pa   <= '0;
         lk_size <= 2'd0;
      end
   end

endmodule

// File: rtl/tagged_tlb_chk.sv
module tagged_tlb_chk #(
   parameter int unsigned VA_W = 48,
   parameter int unsigned PA_W = 40
) (
   input logic            clk,
   input logic            rst_n,
   input logic            lk_en,
   input logic [VA_W-1:0] lk_va,
   input logic            lk_hit,
   input logic [PA_W-1:0] lk_pa,
   input logic [1:0]      lk_size,
   input logic            fl_en,
   input logic            inv_all
);

   a_r1_reset_miss: assert property (@(posedge clk)
      !rst_n |=> !lk_hit);

   a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_en |=> (!lk_hit && (lk_pa == '0) && (lk_size == 2'd0)));

   a_r5_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_size != 2'd3));

   a_r2_small_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && (lk_size == 2'd0)) |-> (lk_pa[11:0] == $past(lk_va[11:0])));

   a_r5_2m_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && (lk_size == 2'd1)) |-> (lk_pa[20:0] == $past(lk_va[20:0])));

   a_r5_4m_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && (lk_size == 2'd2)) |-> (lk_pa[21:0] == $past(lk_va[21:0])));

   a_r7_flush_all_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_all && !fl_en) ##1 lk_en |=> !lk_hit);

endmodule

bind tagged_tlb tagged_tlb_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_va(lk_va),
   .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_size(lk_size),
   .fl_en(fl_en), .inv_all(inv_all)
);

// File: tb/tagged_tlb_test.sv
module tagged_tlb_test;

   localparam int unsigned VA_W = 48;
   localparam int unsigned PA_W = 40;
   localparam int unsigned SN   = 4;
   localparam int unsigned LN   = 2;
   localparam int unsigned AW   = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            lk_en = 1'b0;
   logic [47:0]     lk_va = '0;
   logic [AW-1:0]   lk_asid = '0;
   logic            lk_hit;
   logic [39:0]     lk_pa;
   logic [1:0]      lk_size;
   logic            fl_en = 1'b0;
   logic [35:0]     fl_vpn = '0;
   logic [27:0]     fl_pfn = '0;
   logic [AW-1:0]   fl_asid = '0;
   logic            fl_global = 1'b0;
   logic [1:0]      fl_size = '0;
   logic            inv_all = 1'b0;
   logic            inv_asid_en = 1'b0;
   logic [AW-1:0]   inv_asid = '0;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   tagged_tlb #(.VA_W(VA_W), .PA_W(PA_W), .SMALL_N(SN), .LARGE_N(LN), .ASID_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_va(lk_va), .lk_asid(lk_asid),
      .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_size(lk_size),
      .fl_en(fl_en), .fl_vpn(fl_vpn), .fl_pfn(fl_pfn), .fl_asid(fl_asid),
      .fl_global(fl_global), .fl_size(fl_size),
      .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_asid(inv_asid)
   );

   function automatic logic [39:0] exp_pa(logic [27:0] pfn, logic [47:0] va, logic [1:0] sz);
      case (sz)
         2'd1:    return {pfn[27:9], va[20:0]};
         2'd2:    return {pfn[27:10], va[21:0]};
         default: return {pfn, va[11:0]};
      endcase
   endfunction

   task automatic chk(string req, logic eh, logic [39:0] ep, logic [1:0] es);
      n_cmp++;
      if (lk_hit !== eh || lk_pa !== ep || lk_size !== es) begin
         n_bad++;
         $display("FAIL %s: got hit=%0b pa=%h size=%0d, expected hit=%0b pa=%h size=%0d",
                  req, lk_hit, lk_pa, lk_size, eh, ep, es);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic fill(logic [35:0] vpn, logic [27:0] pfn, logic [AW-1:0] asid,
                       logic g, logic [1:0] sz);
      @(negedge clk);
      fl_en = 1'b1; fl_vpn = vpn; fl_pfn = pfn; fl_asid = asid;
      fl_global = g; fl_size = sz;
      @(negedge clk);
      fl_en = 1'b0;
   endtask

   task automatic look(string req, logic [47:0] va, logic [AW-1:0] asid,
                       logic eh, logic [27:0] pfn, logic [1:0] sz);
      @(negedge clk);
      lk_en = 1'b1; lk_va = va; lk_asid = asid;
      @(negedge clk);
      lk_en = 1'b0;
      chk(req, eh, eh ? exp_pa(pfn, va, sz) : 40'h0, eh ? sz : 2'd0);
   endtask

   task automatic flush(logic all, logic by_id, logic [AW-1:0] id);
      @(negedge clk);
      inv_all = all; inv_asid_en = by_id; inv_asid = id;
      @(negedge clk);
      inv_all = 1'b0; inv_asid_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      // R1: during reset and right after release
      @(negedge clk);
      chk("R1 reset", 1'b0, 40'h0, 2'd0);
      rst_n = 1'b1;
      look("R1 empty lookup", 48'h1234_5678_9ABC, 4'd0, 1'b0, 28'h0, 2'd0);
      @(negedge clk);
      chk("R1 idle output", 1'b0, 40'h0, 2'd0);

      // R2 / R4 small-page translation and identifier tags
      fill(36'h1_2345_6789, 28'hABC_DE12, 4'd1, 1'b0, 2'd0);
      look("R2 small hit", {36'h1_2345_6789, 12'h3C5}, 4'd1, 1'b1, 28'hABC_DE12, 2'd0);
      look("R4 other asid misses", {36'h1_2345_6789, 12'h3C5}, 4'd2, 1'b0, 28'h0, 2'd0);
      fill(36'h0_0000_0ABC, 28'h000_1111, 4'd1, 1'b1, 2'd0);
      look("R4 global any asid", {36'h0_0000_0ABC, 12'h001}, 4'd7, 1'b1, 28'h000_1111, 2'd0);

      // R5 large pages and their boundaries
      fill(36'h4_0000_0123, 28'h55A_A5FF, 4'd1, 1'b0, 2'd1);
      look("R5 2MB hit", {36'h4_0000_01FF, 12'hFFF}, 4'd1, 1'b1, 28'h55A_A5FF, 2'd1);
      look("R5 2MB low edge", {36'h4_0000_0000, 12'h000}, 4'd1, 1'b1, 28'h55A_A5FF, 2'd1);
      look("R5 2MB next page misses", {36'h4_0000_0323, 12'h000}, 4'd1, 1'b0, 28'h0, 2'd0);
      fill(36'h8_0000_0000, 28'h0F0_F3FF, 4'd1, 1'b0, 2'd2);
      look("R5 4MB hit", {36'h8_0000_03FF, 12'h001}, 4'd1, 1'b1, 28'h0F0_F3FF, 2'd2);
      look("R5 4MB next page misses", {36'h8_0000_0400, 12'h001}, 4'd1, 1'b0, 28'h0, 2'd0);

      // R6 flush by identifier
      fill(36'h0_0000_2222, 28'h222_2222, 4'd2, 1'b0, 2'd0);
      flush(1'b0, 1'b1, 4'd1);
      look("R6 asid1 small cleared", {36'h1_2345_6789, 12'h0}, 4'd1, 1'b0, 28'h0, 2'd0);
      look("R6 asid1 large cleared", {36'h4_0000_0100, 12'h0}, 4'd1, 1'b0, 28'h0, 2'd0);
      look("R6 asid2 kept", {36'h0_0000_2222, 12'h010}, 4'd2, 1'b1, 28'h222_2222, 2'd0);
      look("R6 global kept", {36'h0_0000_0ABC, 12'h020}, 4'd1, 1'b1, 28'h000_1111, 2'd0);

      // R7 flush all
      flush(1'b1, 1'b0, 4'd0);
      look("R7 global cleared", {36'h0_0000_0ABC, 12'h020}, 4'd1, 1'b0, 28'h0, 2'd0);
      look("R7 asid2 cleared", {36'h0_0000_2222, 12'h010}, 4'd2, 1'b0, 28'h0, 2'd0);

      // R11 flush-all and fill in one cycle
      @(negedge clk);
      inv_all = 1'b1;
      fl_en = 1'b1; fl_vpn = 36'h0_0000_7777; fl_pfn = 28'h777_7777;
      fl_asid = 4'd3; fl_global = 1'b0; fl_size = 2'd0;
      @(negedge clk);
      inv_all = 1'b0; fl_en = 1'b0;
      look("R11 fill survives flush", {36'h0_0000_7777, 12'h7}, 4'd3, 1'b1, 28'h777_7777, 2'd0);

      // R8 lookup and fill of the same page in one cycle
      @(negedge clk);
      fl_en = 1'b1; fl_vpn = 36'h0_0000_F00F; fl_pfn = 28'h0F0_0F00;
      fl_asid = 4'd3; fl_global = 1'b0; fl_size = 2'd0;
      lk_en = 1'b1; lk_va = {36'h0_0000_F00F, 12'h0AA}; lk_asid = 4'd3;
      @(negedge clk);
      fl_en = 1'b0; lk_en = 1'b0;
      chk("R8 same-cycle lookup sees old", 1'b0, 40'h0, 2'd0);
      look("R8 next lookup hits", {36'h0_0000_F00F, 12'h0AA}, 4'd3, 1'b1, 28'h0F0_0F00, 2'd0);

      // R3 illegal size code dropped
      fill(36'h0_0000_3333, 28'h333_3333, 4'd3, 1'b0, 2'd3);
      look("R3 size code 3 ignored", {36'h0_0000_3333, 12'h0}, 4'd3, 1'b0, 28'h0, 2'd0);

      // R9 duplicate fill overwrites
      do_reset();
      fill(36'h0_0000_0E0E, 28'h100_0001, 4'd3, 1'b0, 2'd0);
      fill(36'h0_0000_0E0E, 28'h100_0002, 4'd3, 1'b0, 2'd0);
      look("R9 duplicate takes new frame", {36'h0_0000_0E0E, 12'h5}, 4'd3, 1'b1, 28'h100_0002, 2'd0);
      for (int k = 0; k < 3; k++)
         fill(36'h0_0000_0A00 + 36'(k), 28'h200_0000 + 28'(k), 4'd3, 1'b0, 2'd0);
      look("R9 single slot used", {36'h0_0000_0E0E, 12'h5}, 4'd3, 1'b1, 28'h100_0002, 2'd0);
      look("R9 pool holds four", {36'h0_0000_0A02, 12'h5}, 4'd3, 1'b1, 28'h200_0002, 2'd0);

      // R10 / R3 replacement sweep with a resident large page
      do_reset();
      fill(36'h6_0000_0000, 28'h6AB_CE00, 4'd5, 1'b0, 2'd1);
      for (int k = 0; k < 3 * SN; k++) begin
         fill(36'h0_0000_1000 + 36'(k), 28'h030_0000 + 28'(k), 4'd5, 1'b0, 2'd0);
         look("R10 newest hits", {36'h0_0000_1000 + 36'(k), 12'h123}, 4'd5,
              1'b1, 28'h030_0000 + 28'(k), 2'd0);
         for (int j = 1; j < SN; j++) begin
            if (k - j >= 0)
               look("R10 recent kept", {36'h0_0000_1000 + 36'(k - j), 12'h456}, 4'd5,
                    1'b1, 28'h030_0000 + 28'(k - j), 2'd0);
         end
         if (k >= SN)
            look("R10 oldest evicted", {36'h0_0000_1000 + 36'(k - SN), 12'h0}, 4'd5,
                 1'b0, 28'h0, 2'd0);
      end
      look("R3 large untouched by small fills", {36'h6_0000_0155, 12'h9}, 4'd5,
           1'b1, 28'h6AB_CE00, 2'd1);

      // R10 large pool round robin
      fill(36'h7_0000_0000, 28'h7000_000, 4'd5, 1'b0, 2'd2);
      fill(36'h5_0000_0000, 28'h5000_000, 4'd5, 1'b0, 2'd1);
      look("R10 large oldest evicted", {36'h6_0000_0000, 12'h0}, 4'd5, 1'b0, 28'h0, 2'd0);
      look("R10 large 4MB kept", {36'h7_0000_0200, 12'h0}, 4'd5, 1'b1, 28'h7000_000, 2'd2);
      look("R10 large newest", {36'h5_0000_0001, 12'h0}, 4'd5, 1'b1, 28'h5000_000, 2'd1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule